// File: doc/BRIEF.md
# Indexed codec control register file

This block is the host-side control window of an audio codec. A host reaches it through four byte-wide direct locations, picked by a two-bit address: an index pointer, a data port that reaches the indirect register the pointer selects, a status byte and a programmed-I/O data byte. Behind the data port sits a bank of 32 indirect 8-bit control registers. Each register has its own reset value and its own write rule. The block exposes the current playback format byte together with a one-cycle strobe that marks an accepted format change.

Only the low 16 indirect registers can be reached until software sets the extended-mode bit in the mode register. After that, the full 32 can be reached. Format changes are gated by two enable bits: a full-change enable in the index pointer and a partial-change enable in the interrupt/feature status register. The block also keeps the interrupt state. A pulse on the playback-done input raises the interrupt. Any write to the status location clears every pending source.

All writes take effect on the rising clock edge on which `wr_en_i` is high. Reads are combinational from `addr_i` and the current index.

Top module: `codec_regfile`

## Requirements
- R1: The direct location is `addr_i`: 0 is the index pointer, 1 is the indirect data port, 2 is the status byte and 3 is the programmed-I/O byte. The status byte reads as bit 0 = global interrupt, with all other bits 0.
- R2: The index pointer resets to 0x40. A write stores the value with bit 7 cleared, and a read of location 0 always returns bit 7 as 0. Bit 6 of the index pointer is the full format-change enable.
- R3: The indirect register number is index bits [3:0] while the extended-mode bit (bit 6 of register 12) is 0, and index bits [4:0] while it is 1.
- R4: Indirect reset values: registers 2, 3, 4, 5, 18 and 19 reset to 0x88. Registers 6 and 7 reset to 0x80. Register 9 resets to 0x08, register 12 to 0x8A, and registers 25 and 26 to 0xA0. All other registers reset to 0x00.
- R5: A write to register 8 (playback format) is handled as follows. If index bit 6 is 1, the whole byte is stored. Otherwise, if bit 1 of register 24 is 1, only bits [7:4] change. Otherwise the write is ignored. `fmt_o` always shows register 8.
- R6: `fmt_upd_o` is high for exactly the one cycle after the edge that accepts a register 8 write. An ignored write to register 8 does not raise it.
- R7: A write to register 9 stores bit 5 as 0.
- R8: Writes to register 11 are ignored. A write to register 12 changes only its bit 6.
- R9: A one-cycle `pb_done_i` pulse sets status bit 0, bit 4 of register 24 and `irq_o` from the next cycle on.
- R10: Any write to location 2 clears status bit 0, clears bits 4, 5 and 6 of register 24, and clears `irq_o` on the next cycle. If `pb_done_i` is high in the same cycle, that pulse wins and leaves bit 4 and the interrupt set.
- R11: A write to register 24 that takes bit 4 from 1 to 0 clears the interrupt. A write that keeps bit 4 at 1, or sets it from 0, leaves the interrupt unchanged.
- R12: Writes to location 3 are ignored, and reads of location 3 return 0x00.
- R13: Every indirect register not named in R5, R7, R8 or R10 stores the full byte written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Direct location select |
| wr_en_i | input | 1 | Write strobe for the selected location |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected location (combinational) |
| pb_done_i | input | 1 | Playback-done event pulse |
| irq_o | output | 1 | Interrupt line |
| fmt_o | output | 8 | Current playback format byte |
| fmt_upd_o | output | 1 | One-cycle strobe after an accepted format write |

## Verification
Every result of a write or an event is registered once, so it is visible one clock edge after the stimulus. Reads are combinational and add no delay. The bench drives inputs on the falling edge and samples at the following falling edge, which is half a cycle after the capturing edge. At that point register contents, `irq_o` and the still-high `fmt_upd_o` strobe are all due. It then samples once more, one cycle later, to confirm that the strobe has dropped. Collisions, such as an event arriving together with a status write, are driven within a single cycle so that the priority rule is what gets checked.

// File: rtl/codec_regfile_pkg.sv
package codec_regfile_pkg;

  typedef enum logic [1:0] {
    LOC_INDEX  = 2'd0,
    LOC_DATA   = 2'd1,
    LOC_STATUS = 2'd2,
    LOC_PIO    = 2'd3
  } loc_e;

  localparam int unsigned IX_FMT   = 8;
  localparam int unsigned IX_IFC   = 9;
  localparam int unsigned IX_ERR   = 11;
  localparam int unsigned IX_MODE  = 12;
  localparam int unsigned IX_ALTST = 24;

  localparam int unsigned MCE_BIT  = 6;
  localparam int unsigned EXT_BIT  = 6;
  localparam int unsigned PMCE_BIT = 1;
  localparam int unsigned PI_BIT   = 4;
  localparam int unsigned CI_BIT   = 5;
  localparam int unsigned TI_BIT   = 6;
  localparam int unsigned IFC_RSVD = 5;

  localparam logic [7:0] IDX_RST   = 8'h40;
  localparam logic [7:0] PIO_VAL   = 8'h00;
  localparam logic [7:0] FLAG_MASK = 8'((1 << PI_BIT) | (1 << CI_BIT) | (1 << TI_BIT));

  typedef struct packed {
    logic       accept;
    logic [7:0] val;
  } wr_res_t;

  function automatic logic [7:0] rst_val(input int unsigned idx);
    case (idx)
      2, 3, 4, 5, 18, 19: rst_val = 8'h88;
      6, 7:               rst_val = 8'h80;
      9:                  rst_val = 8'h08;
      12:                 rst_val = 8'h8A;
      25, 26:             rst_val = 8'hA0;
      default:            rst_val = 8'h00;
    endcase
  endfunction

  // per-register write rule; register 24 flag overlay is applied in the bank
  function automatic wr_res_t write_rule(input int unsigned idx, input logic [7:0] old_v,
                                         input logic [7:0] wd, input logic mce,
                                         input logic pmce);
    wr_res_t r;
    r.accept = 1'b1;
    r.val    = wd;
    case (idx)
      IX_FMT: begin
        if (mce)       r.val = wd;
        else if (pmce) r.val = {wd[7:4], old_v[3:0]};
        else           r.accept = 1'b0;
      end
      IX_IFC:  r.val[IFC_RSVD] = 1'b0;
      IX_ERR:  r.accept = 1'b0;
      IX_MODE: begin
        r.val          = old_v;
        r.val[EXT_BIT] = wd[EXT_BIT];
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cr_index.sv
module cr_index #(
  parameter int unsigned IW  = 5,
  parameter int unsigned NIW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [6:0]    wdata_i,
  input  logic          ext_i,
  output logic [7:0]    idx_o,
  output logic          mce_o,
  output logic [IW-1:0] iaddr_o
);
  import codec_regfile_pkg::*;

  logic [6:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_q <= IDX_RST[6:0];
    else if (wr_i) idx_q <= wdata_i;
  end

  assign idx_o = {1'b0, idx_q};
  assign mce_o = idx_q[MCE_BIT];

  if (NIW < IW) begin : g_narrow
    assign iaddr_o = ext_i ? idx_q[IW-1:0] : {{(IW-NIW){1'b0}}, idx_q[NIW-1:0]};
  end else begin : g_flat
    assign iaddr_o = idx_q[IW-1:0];
  end

  AST_IDX_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> idx_o == {1'b0, $past(wdata_i)}); // R2

endmodule

// File: rtl/cr_bank.sv
module cr_bank #(
  parameter int unsigned NREG = 32,
  parameter int unsigned IW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] iaddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          mce_i,
  input  logic          flag_clr_i,
  input  logic          pb_evt_i,
  output logic [7:0]    rd_o,
  output logic          ext_o,
  output logic          pi_fall_o,
  output logic [7:0]    fmt_o,
  output logic          fmt_upd_o
);
  import codec_regfile_pkg::*;

  logic [7:0] regs_q [NREG];
  logic       pmce;
  logic       fmt_ok;
  logic       fmt_upd_q;

  assign pmce   = regs_q[IX_ALTST][PMCE_BIT];
  assign fmt_ok = mce_i | pmce;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    wr_res_t    res;
    logic       hit;
    logic [7:0] nxt;

    assign hit = wr_i && (iaddr_i == IW'(g));
    assign res = write_rule(g, regs_q[g], wdata_i, mce_i, pmce);

    if (g == IX_ALTST) begin : g_alt
      always_comb begin
        nxt = (hit && res.accept) ? res.val : regs_q[g];
        if (flag_clr_i) nxt = nxt & ~FLAG_MASK;
        if (pb_evt_i)   nxt[PI_BIT] = 1'b1;
      end
    end else begin : g_std
      assign nxt = (hit && res.accept) ? res.val : regs_q[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= rst_val(g);
      else         regs_q[g] <= nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fmt_upd_q <= 1'b0;
    else         fmt_upd_q <= wr_i && (iaddr_i == IW'(IX_FMT)) && fmt_ok;
  end

  assign rd_o      = regs_q[iaddr_i];
  assign ext_o     = regs_q[IX_MODE][EXT_BIT];
  assign fmt_o     = regs_q[IX_FMT];
  assign fmt_upd_o = fmt_upd_q;
  assign pi_fall_o = wr_i && (iaddr_i == IW'(IX_ALTST)) &&
                     regs_q[IX_ALTST][PI_BIT] && !wdata_i[PI_BIT];

  AST_ERR_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && iaddr_i == IW'(IX_ERR)) |=> $stable(regs_q[IX_ERR])); // R8
  AST_MODE_EXT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && iaddr_i == IW'(IX_MODE)) |=>
      ({regs_q[IX_MODE][7], regs_q[IX_MODE][5:0]} ==
       $past({regs_q[IX_MODE][7], regs_q[IX_MODE][5:0]}))); // R8
  AST_FMT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && iaddr_i == IW'(IX_FMT) && !mce_i && !pmce) |=> $stable(fmt_o)); // R5
  AST_FMT_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && iaddr_i == IW'(IX_FMT) && !mce_i && pmce) |=> $stable(fmt_o[3:0])); // R5
  AST_IFC_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && iaddr_i == IW'(IX_IFC)) |=> !regs_q[IX_IFC][IFC_RSVD]); // R7
  AST_FMT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_upd_o |-> $past(wr_i && iaddr_i == IW'(IX_FMT))); // R6

endmodule

// File: rtl/cr_irq.sv
module cr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pb_evt_i,
  input  logic stat_wr_i,
  input  logic pi_fall_i,
  output logic int_o
);
  logic int_q;

  // a fresh event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     int_q <= 1'b0;
    else if (pb_evt_i)               int_q <= 1'b1;
    else if (stat_wr_i || pi_fall_i) int_q <= 1'b0;
  end

  assign int_o = int_q;

  AST_EVT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_evt_i |=> int_o); // R9
  AST_STATUS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && !pb_evt_i) |=> !int_o); // R10
  AST_PI_FALL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pi_fall_i && !pb_evt_i) |=> !int_o); // R11
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pb_evt_i && !stat_wr_i && !pi_fall_i) |=> $stable(int_o)); // R11

endmodule

// File: rtl/codec_regfile.sv
module codec_regfile #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned NARROW = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       pb_done_i,
  output logic       irq_o,
  output logic [7:0] fmt_o,
  output logic       fmt_upd_o
);
  import codec_regfile_pkg::*;

  localparam int unsigned IW  = $clog2(NREG);
  localparam int unsigned NIW = $clog2(NARROW);

  loc_e          loc;
  logic          wr_idx, wr_dat, wr_stat;
  logic [7:0]    idx;
  logic          mce, ext, pi_fall, int_s;
  logic [IW-1:0] iaddr;
  logic [7:0]    bank_rd;

  assign loc     = loc_e'(addr_i);
  assign wr_idx  = wr_en_i && (loc == LOC_INDEX);
  assign wr_dat  = wr_en_i && (loc == LOC_DATA);
  assign wr_stat = wr_en_i && (loc == LOC_STATUS);

  cr_index #(.IW(IW), .NIW(NIW)) u_index (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_idx),
    .wdata_i (wdata_i[6:0]),
    .ext_i   (ext),
    .idx_o   (idx),
    .mce_o   (mce),
    .iaddr_o (iaddr)
  );

  cr_bank #(.NREG(NREG), .IW(IW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_dat),
    .iaddr_i    (iaddr),
    .wdata_i    (wdata_i),
    .mce_i      (mce),
    .flag_clr_i (wr_stat),
    .pb_evt_i   (pb_done_i),
    .rd_o       (bank_rd),
    .ext_o      (ext),
    .pi_fall_o  (pi_fall),
    .fmt_o      (fmt_o),
    .fmt_upd_o  (fmt_upd_o)
  );

  cr_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pb_evt_i  (pb_done_i),
    .stat_wr_i (wr_stat),
    .pi_fall_i (pi_fall),
    .int_o     (int_s)
  );

  always_comb begin
    case (loc)
      LOC_INDEX:  rdata_o = idx;
      LOC_DATA:   rdata_o = bank_rd;
      LOC_STATUS: rdata_o = {7'b0, int_s};
      default:    rdata_o = PIO_VAL;
    endcase
  end

  assign irq_o = int_s;

  AST_IDX_READ_B7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc == LOC_INDEX) |-> !rdata_o[7]); // R2
  AST_PIO_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc == LOC_PIO) |-> rdata_o == 8'h00); // R12
  AST_IRQ_MATCH_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc == LOC_STATUS) |-> rdata_o == {7'b0, irq_o}); // R1

endmodule

// File: tb/codec_regfile_tb.sv
`timescale 1ns/100ps
module codec_regfile_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       pb_done = 1'b0;
  logic [7:0] rdata, fmt;
  logic       irq, fmt_upd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] exp_r [32];
  logic       m_mce, m_ext;

  always #2.5 clk = ~clk;

  codec_regfile u_dut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wr_en_i (wr_en),
    .wdata_i (wdata), .rdata_o (rdata), .pb_done_i (pb_done),
    .irq_o (irq), .fmt_o (fmt), .fmt_upd_o (fmt_upd)
  );

  function automatic logic [7:0] reset_of(input int i);
    if (i inside {2, 3, 4, 5, 18, 19}) return 8'h88;
    if (i == 6 || i == 7) return 8'h80;
    if (i == 9) return 8'h08;
    if (i == 12) return 8'h8A;
    if (i == 25 || i == 26) return 8'hA0;
    return 8'h00;
  endfunction

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic set_index(input logic [7:0] v);
    wr(2'd0, v);
    m_mce = v[6];
  endtask

  task automatic pulse_done;
    @(negedge clk);
    pb_done = 1'b1;
    @(negedge clk);
    pb_done = 1'b0;
  endtask

  // model of one indirect write, taken from the requirements
  task automatic model_write(input int g, input logic [7:0] d);
    logic [7:0] o;
    o = exp_r[g];
    case (g)
      8:  if (m_mce) exp_r[g] = d;
          else if (exp_r[24][1]) exp_r[g] = {d[7:4], o[3:0]};
      9:  exp_r[g] = d & 8'hDF;
      11: ;
      12: exp_r[g] = (o & 8'hBF) | (d & 8'h40);
      default: exp_r[g] = d;
    endcase
    m_ext = exp_r[12][6];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] pats [4];
    pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5; pats[3] = 8'h5A;
    for (int i = 0; i < 32; i++) exp_r[i] = reset_of(i);
    m_mce = 1'b1; m_ext = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(2'd0, v); chk(v, 8'h40, "R2 index reset");
    rd(2'd2, v); chk(v, 8'h00, "R1 status reset");
    rd(2'd3, v); chk(v, 8'h00, "R12 pio reset");
    chk({7'b0, irq}, 8'h00, "R9 irq reset");
    chk(fmt, 8'h00, "R5 fmt reset");
    chk({7'b0, fmt_upd}, 8'h00, "R6 strobe reset");

    // narrow window reset values
    for (int g = 0; g < 16; g++) begin
      set_index(8'(g));
      rd(2'd1, v); chk(v, reset_of(g), $sformatf("R4 reset reg%0d", g));
    end

    // mode register: only bit 6 changes, opens the wide window
    set_index(8'd12);
    wr(2'd1, 8'hFF); model_write(12, 8'hFF);
    rd(2'd1, v); chk(v, 8'hCA, "R8 mode write");
    for (int g = 16; g < 32; g++) begin
      set_index(8'(g));
      rd(2'd1, v); chk(v, reset_of(g), $sformatf("R4 reset reg%0d", g));
    end

    // read-only error register
    set_index(8'd11);
    wr(2'd1, 8'hFF); model_write(11, 8'hFF);
    rd(2'd1, v); chk(v, 8'h00, "R8 error reg read-only");

    // full sweep with full-change enable set
    for (int g = 0; g < 32; g++) begin
      if (g == 11 || g == 12) continue;
      for (int p = 0; p < 4; p++) begin
        set_index(8'(g) | 8'h40);
        wr(2'd1, pats[p]);
        if (g == 8) chk({7'b0, fmt_upd}, 8'h01, "R6 strobe on accepted write");
        model_write(g, pats[p]);
        rd(2'd1, v);
        chk(v, exp_r[g], (g == 9) ? "R7 iface bit5" :
                         (g == 8) ? "R5 full format write" :
                         $sformatf("R13 store reg%0d", g));
        if (g == 8) begin
          chk({7'b0, fmt_upd}, 8'h00, "R6 strobe one cycle");
          chk(fmt, exp_r[8], "R5 fmt_o follows reg8");
        end
      end
    end

    // partial format change
    set_index(8'd24 | 8'h40); wr(2'd1, 8'h02); model_write(24, 8'h02);
    set_index(8'd8 | 8'h40);  wr(2'd1, 8'h3C); model_write(8, 8'h3C);
    set_index(8'd8);
    wr(2'd1, 8'hF1);
    chk({7'b0, fmt_upd}, 8'h01, "R6 strobe on partial write");
    model_write(8, 8'hF1);
    chk(fmt, 8'hFC, "R5 partial format write");
    set_index(8'd24); wr(2'd1, 8'h00); model_write(24, 8'h00);
    set_index(8'd8);
    wr(2'd1, 8'h77);
    chk({7'b0, fmt_upd}, 8'h00, "R6 no strobe on ignored write");
    chk(fmt, 8'hFC, "R5 format write ignored");

    // narrow aliasing
    set_index(8'd12); wr(2'd1, 8'h00); model_write(12, 8'h00);
    set_index(8'h18);
    rd(2'd1, v); chk(v, 8'hFC, "R3 narrow index aliases reg8");
    set_index(8'd12); wr(2'd1, 8'h40); model_write(12, 8'h40);
    set_index(8'h18);
    rd(2'd1, v); chk(v, 8'h00, "R3 wide index reaches reg24");

    // interrupts
    wr(2'd1, 8'h60); model_write(24, 8'h60);
    chk({7'b0, irq}, 8'h00, "R11 setting flags by write leaves irq");
    pulse_done;
    chk({7'b0, irq}, 8'h01, "R9 event raises irq");
    rd(2'd2, v); chk(v, 8'h01, "R1 status shows int");
    set_index(8'd24);
    rd(2'd1, v); chk(v, 8'h70, "R9 event sets flag bit4");
    wr(2'd2, 8'h00);
    chk({7'b0, irq}, 8'h00, "R10 status write clears irq");
    rd(2'd1, v); chk(v, 8'h00, "R10 flags cleared");
    rd(2'd2, v); chk(v, 8'h00, "R10 status cleared");

    pulse_done;
    wr(2'd1, 8'h10);
    chk({7'b0, irq}, 8'h01, "R11 bit4 kept high keeps irq");
    wr(2'd1, 8'h00);
    chk({7'b0, irq}, 8'h00, "R11 bit4 falling clears irq");
    wr(2'd1, 8'h10);
    chk({7'b0, irq}, 8'h00, "R11 bit4 rising leaves irq low");

    // event and status clear in the same cycle
    @(negedge clk);
    addr = 2'd2; wdata = 8'hFF; wr_en = 1'b1; pb_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pb_done = 1'b0;
    chk({7'b0, irq}, 8'h01, "R10 event wins over clear");
    rd(2'd1, v); chk(v, 8'h10, "R10 flag bit4 kept on collision");
    wr(2'd2, 8'h00);

    // programmed-I/O and index bit 7
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk(v, 8'h00, "R12 pio write ignored");
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk(v, 8'h7F, "R2 index bit7 forced low");
    rd(2'd1, v); chk(v, exp_r[31], "R3 index 0xFF maps to reg31");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule